// File: doc/BRIEF.md
# Received Frame Word Buffer

This block sits between a CAN / CAN FD protocol engine and a host read port. It keeps received frames in a circular memory of 32-bit words. The engine opens a frame with a start-of-frame strobe, which also latches the free-running 64-bit timestamp. It then presents the frame metadata and identifier with a header strobe, pushes one packed data word per data strobe, and ends the frame with either a commit strobe or an abort strobe. The host sees the stored words one at a time on a read port and steps through them with a read-advance strobe.

A frame is admitted or refused as a whole when its header arrives. The block computes the frame's total size from the length code and the format flags, and compares it with the space that committed frames leave free. Words of an open frame go to a speculative write position. The committed write position, which sets the empty flag, moves only on commit. Abort, or a new start-of-frame, rolls the speculative position back. A refused frame raises a sticky overrun flag, and everything else for that frame is ignored.

After the header strobe, the four header words are written on the four following cycles. The engine must leave at least five cycles between the header strobe and its first data strobe or its commit.

Top module: `rx_frame_buffer`

## Requirements
- R1: After a synchronous reset, the empty flag is 1, the overrun flag is 0, and both pointer positions are 0.
- R2: A committed frame reads back in this order: format word, identifier word `{3'b000, id[28:0]}`, timestamp bits 31:0, timestamp bits 63:32, then the data words in strobe order. The timestamp is the value present at the start-of-frame strobe.
- R3: Format word bit layout: bits 3:0 hold the length code, bit 4 the remote flag, bit 5 the extended-identifier flag, bit 6 the FD flag, bit 7 the error-state flag, and bits 12:8 the number of words that follow the format word (3 plus the data word count). All other bits are 0.
- R4: Data word count. A remote frame without the FD flag has 0 data words. Otherwise the count is ceil(bytes/4). Codes 0 to 8 give 0 to 8 bytes. Codes 9 to 15 give 12, 16, 20, 24, 32, 48 and 64 bytes with the FD flag set, and 8 bytes without it. Data strobes beyond the count are ignored.
- R5: A frame changes the empty flag and the write position only on its commit strobe. The empty flag is 1 exactly when no committed word is left unread.
- R6: An abort strobe, or a new start-of-frame strobe, during an open frame discards every word of that frame. The write position stays where it was, and no word of the frame is ever readable.
- R7: If a frame's total size (4 plus its data words) exceeds the free word count at its header strobe, the overrun flag is set and the frame is dropped whole. The flag stays set until the clear input is pulsed (a set in the same cycle wins). Frames after the drop are stored normally.
- R8: Each read-advance strobe while not empty moves the read position forward by one word, wrapping from DEPTH-1 to 0, and frees one word. A read-advance strobe while empty is ignored.
- R9: The read and write positions are presented as 12-bit values, zero-extended from the pointer width. The write position is the committed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_i | input | 64 | Free-running timestamp |
| sof_i | input | 1 | Start-of-frame strobe; latches timestamp and opens a frame |
| hdr_i | input | 1 | Header strobe; samples metadata and identifier |
| dlc_i | input | 4 | Length code |
| rtr_i | input | 1 | Remote frame flag |
| fd_i | input | 1 | FD format flag |
| ext_id_i | input | 1 | Extended identifier flag |
| esi_i | input | 1 | Error-state flag of the sender |
| id_i | input | 29 | Identifier |
| data_we_i | input | 1 | Data word store strobe |
| data_i | input | 32 | Data word, byte 4i in bits 7:0 |
| commit_i | input | 1 | Frame received correctly; publish it |
| abort_i | input | 1 | Frame failed; discard it |
| rd_adv_i | input | 1 | Advance to the next stored word |
| rd_word_o | output | 32 | Word at the read position |
| empty_o | output | 1 | No committed word waiting |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_pos_o | output | 12 | Read position |
| wr_pos_o | output | 12 | Committed write position |

## Verification
The bench fills the memory to exactly full: three 20-word frames and then a 4-word frame in a 64-word store. A design that admits frames with an off-by-one free count would refuse that last frame, or would accept a 20-word frame that overwrites unread words. It aborts frames in mid-data and restarts a frame with a fresh start-of-frame strobe. A design that commits speculative words early would show them to the reader or move the write position. It sends remote frames with and without the FD flag, classic frames with codes above 8, and surplus data strobes. A wrong length decode then shows up as misplaced words and a drifting write position. Because the read position wraps across many frames, a pointer that fails to wrap at the memory depth gives wrong read words.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

  localparam int unsigned HDR_WORDS = 4;
  localparam int unsigned POS_W     = 12;

  // Payload byte count from the length code; classic frames cap at 8.
  function automatic logic [6:0] dlc_to_bytes(input logic [3:0] dlc, input logic fd);
    logic [6:0] b;
    if (dlc <= 4'd8) begin
      b = {3'b000, dlc};
    end else if (!fd) begin
      b = 7'd8;
    end else begin
      case (dlc)
        4'd9:    b = 7'd12;
        4'd10:   b = 7'd16;
        4'd11:   b = 7'd20;
        4'd12:   b = 7'd24;
        4'd13:   b = 7'd32;
        4'd14:   b = 7'd48;
        default: b = 7'd64;
      endcase
    end
    return b;
  endfunction

  // Number of 32-bit data words a frame occupies.
  function automatic logic [4:0] data_words(input logic [3:0] dlc, input logic rtr,
                                            input logic fd);
    int unsigned w;
    if (rtr && !fd) begin
      w = 0;
    end else begin
      w = (int'(dlc_to_bytes(dlc, fd)) + 3) / 4;
    end
    return 5'(w);
  endfunction

  // Format word: [3:0] code, [4] remote, [5] ext id, [6] fd, [7] esi,
  // [12:8] words following the format word.
  function automatic logic [31:0] pack_fmt(input logic [3:0] dlc, input logic rtr,
                                           input logic ext, input logic fd,
                                           input logic esi, input logic [4:0] ndata);
    logic [4:0] tail;
    tail = ndata + 5'd3;
    return {19'd0, tail, esi, fd, ext, rtr, dlc};
  endfunction

endpackage

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Registered read port; reset only touches the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/rxfb_wr_ctrl.sv
module rxfb_wr_ctrl
  import rxfb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [63:0]      ts_i,
  input  logic             sof_i,
  input  logic             hdr_i,
  input  logic [3:0]       dlc_i,
  input  logic             rtr_i,
  input  logic             fd_i,
  input  logic             ext_id_i,
  input  logic             esi_i,
  input  logic [28:0]      id_i,
  input  logic             data_we_i,
  input  logic [31:0]      data_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             ovr_clr_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_waddr_o,
  output logic [31:0]      mem_wdata_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_cnt_o,
  output logic [PTR_W-1:0] wr_com_o,
  output logic             ovr_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic             in_frame_q, drop_q, hdr_act_q, ovr_q;
  logic [1:0]       hdr_idx_q;
  logic [PTR_W-1:0] spec_q, com_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [4:0]       need_q;
  logic [63:0]      ts_q;
  logic [31:0]      fmt_q;
  logic [28:0]      id_q;

  logic        restart, take_commit, take_hdr, fits, hdr_write, data_write;
  logic [4:0]  ndata;
  int unsigned frame_size;
  logic [31:0] hdr_word;

  always_comb begin
    ndata       = data_words(dlc_i, rtr_i, fd_i);
    frame_size  = 32'(ndata) + HDR_WORDS;
    fits        = frame_size <= 32'(free_i);
    restart     = sof_i | abort_i;
    take_commit = !restart && commit_i;
    take_hdr    = !restart && !commit_i && hdr_i && in_frame_q && !drop_q &&
                  !hdr_act_q && (wcnt_q == '0);
    hdr_write   = !restart && !commit_i && hdr_act_q;
    data_write  = !restart && !commit_i && !hdr_act_q && data_we_i && in_frame_q &&
                  !drop_q && (wcnt_q >= CNT_W'(HDR_WORDS)) && (need_q != 5'd0);
    case (hdr_idx_q)
      2'd0:    hdr_word = fmt_q;
      2'd1:    hdr_word = {3'b000, id_q};
      2'd2:    hdr_word = ts_q[31:0];
      default: hdr_word = ts_q[63:32];
    endcase
  end

  assign mem_we_o     = hdr_write | data_write;
  assign mem_waddr_o  = spec_q;
  assign mem_wdata_o  = hdr_write ? hdr_word : data_i;
  assign commit_o     = take_commit && in_frame_q && !drop_q;
  assign commit_cnt_o = wcnt_q;
  assign wr_com_o     = com_q;
  assign ovr_o        = ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      hdr_act_q  <= 1'b0;
      hdr_idx_q  <= 2'd0;
      spec_q     <= '0;
      com_q      <= '0;
      wcnt_q     <= '0;
      need_q     <= 5'd0;
      ts_q       <= '0;
      fmt_q      <= '0;
      id_q       <= '0;
    end else if (restart) begin
      spec_q     <= com_q;
      wcnt_q     <= '0;
      hdr_act_q  <= 1'b0;
      drop_q     <= 1'b0;
      need_q     <= 5'd0;
      in_frame_q <= sof_i;
      if (sof_i) begin
        ts_q <= ts_i;
      end
    end else if (take_commit) begin
      if (commit_o) begin
        com_q <= spec_q;
      end else begin
        spec_q <= com_q;
      end
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      hdr_act_q  <= 1'b0;
      wcnt_q     <= '0;
      need_q     <= 5'd0;
    end else begin
      if (take_hdr) begin
        if (fits) begin
          hdr_act_q <= 1'b1;
          hdr_idx_q <= 2'd0;
          fmt_q     <= pack_fmt(dlc_i, rtr_i, ext_id_i, fd_i, esi_i, ndata);
          id_q      <= id_i;
          need_q    <= ndata;
        end else begin
          drop_q <= 1'b1;
        end
      end
      if (mem_we_o) begin
        spec_q <= step(spec_q);
        wcnt_q <= wcnt_q + 1'b1;
      end
      if (hdr_write) begin
        hdr_idx_q <= hdr_idx_q + 2'd1;
        if (hdr_idx_q == 2'd3) begin
          hdr_act_q <= 1'b0;
        end
      end
      if (data_write) begin
        need_q <= need_q - 5'd1;
      end
    end
  end

  // Sticky overrun; a new refusal wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
    end else if (take_hdr && !fits) begin
      ovr_q <= 1'b1;
    end else if (ovr_clr_i) begin
      ovr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rxfb_rd_ctrl.sv
module rxfb_rd_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_adv_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_cnt_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_nxt_o,
  output logic [CNT_W-1:0] free_o,
  output logic             empty_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] rd_q;
  logic [CNT_W-1:0] used_q, used_nxt;
  logic             adv;

  always_comb begin
    adv          = rd_adv_i && (used_q != '0);
    rd_ptr_nxt_o = adv ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
    used_nxt     = used_q + (commit_i ? commit_cnt_i : '0) - CNT_W'(adv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      used_q <= '0;
    end else begin
      rd_q   <= rd_ptr_nxt_o;
      used_q <= used_nxt;
    end
  end

  assign rd_ptr_o = rd_q;
  assign free_o   = CNT_W'(DEPTH) - used_q;
  assign empty_o  = (used_q == '0);

endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rxfb_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] ts_i,
  input  logic        sof_i,
  input  logic        hdr_i,
  input  logic [3:0]  dlc_i,
  input  logic        rtr_i,
  input  logic        fd_i,
  input  logic        ext_id_i,
  input  logic        esi_i,
  input  logic [28:0] id_i,
  input  logic        data_we_i,
  input  logic [31:0] data_i,
  input  logic        commit_i,
  input  logic        abort_i,
  input  logic        rd_adv_i,
  output logic [31:0] rd_word_o,
  output logic        empty_o,
  output logic        ovr_o,
  input  logic        ovr_clr_i,
  output logic [11:0] rd_pos_o,
  output logic [11:0] wr_pos_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic             mem_we, commit;
  logic [PTR_W-1:0] mem_waddr, wr_com, rd_ptr, rd_ptr_nxt;
  logic [31:0]      mem_wdata;
  logic [CNT_W-1:0] commit_cnt, free;

  rxfb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .ts_i(ts_i), .sof_i(sof_i), .hdr_i(hdr_i),
    .dlc_i(dlc_i), .rtr_i(rtr_i), .fd_i(fd_i), .ext_id_i(ext_id_i), .esi_i(esi_i),
    .id_i(id_i), .data_we_i(data_we_i), .data_i(data_i), .commit_i(commit_i),
    .abort_i(abort_i), .ovr_clr_i(ovr_clr_i), .free_i(free),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .commit_o(commit), .commit_cnt_o(commit_cnt), .wr_com_o(wr_com), .ovr_o(ovr_o)
  );

  rxfb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .rd_adv_i(rd_adv_i), .commit_i(commit),
    .commit_cnt_i(commit_cnt), .rd_ptr_o(rd_ptr), .rd_ptr_nxt_o(rd_ptr_nxt),
    .free_o(free), .empty_o(empty_o)
  );

  rxfb_mem #(.DEPTH(DEPTH), .WIDTH(32)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_ptr_nxt), .rdata(rd_word_o)
  );

  assign rd_pos_o = POS_W'(rd_ptr);
  assign wr_pos_o = POS_W'(wr_com);

endmodule

// File: rtl/rxfb_chk.sv
module rxfb_chk #(
  parameter int unsigned DEPTH = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_adv_i,
  input logic        commit_i,
  input logic        abort_i,
  input logic        ovr_clr_i,
  input logic        empty_o,
  input logic        ovr_o,
  input logic [11:0] rd_pos_o,
  input logic [11:0] wr_pos_o
);

  localparam logic [11:0] LASTPOS = 12'(DEPTH - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (empty_o && !ovr_o && rd_pos_o == 12'd0 && wr_pos_o == 12'd0));

  // R5
  wr_pos_commit_only_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> (wr_pos_o == $past(wr_pos_o)));

  // R5
  empty_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> (rd_pos_o == wr_pos_o));

  // R6
  abort_holds_wr_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> $stable(wr_pos_o));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  // R8
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    empty_o |=> (rd_pos_o == $past(rd_pos_o)));

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_adv_i && !empty_o) |=>
      (rd_pos_o == (($past(rd_pos_o) == LASTPOS) ? 12'd0 : $past(rd_pos_o) + 12'd1)));

endmodule

bind rx_frame_buffer rxfb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_adv_i(rd_adv_i), .commit_i(commit_i),
  .abort_i(abort_i), .ovr_clr_i(ovr_clr_i), .empty_o(empty_o), .ovr_o(ovr_o),
  .rd_pos_o(rd_pos_o), .wr_pos_o(wr_pos_o)
);

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb;

  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [63:0] ts_i = 64'hA5A5_0001_0000_0100;
  logic        sof_i = 0, hdr_i = 0, rtr_i = 0, fd_i = 0, ext_id_i = 0, esi_i = 0;
  logic [3:0]  dlc_i = 0;
  logic [28:0] id_i = 0;
  logic        data_we_i = 0, commit_i = 0, abort_i = 0, rd_adv_i = 0, ovr_clr_i = 0;
  logic [31:0] data_i = 0;
  logic [31:0] rd_word_o;
  logic        empty_o, ovr_o;
  logic [11:0] rd_pos_o, wr_pos_o;

  always @(posedge clk) ts_i <= ts_i + 64'd1;

  rx_frame_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ts_i(ts_i), .sof_i(sof_i), .hdr_i(hdr_i), .dlc_i(dlc_i),
    .rtr_i(rtr_i), .fd_i(fd_i), .ext_id_i(ext_id_i), .esi_i(esi_i), .id_i(id_i),
    .data_we_i(data_we_i), .data_i(data_i), .commit_i(commit_i), .abort_i(abort_i),
    .rd_adv_i(rd_adv_i), .rd_word_o(rd_word_o), .empty_o(empty_o), .ovr_o(ovr_o),
    .ovr_clr_i(ovr_clr_i), .rd_pos_o(rd_pos_o), .wr_pos_o(wr_pos_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected data words (R4).
  function automatic int exp_ndata(input logic [3:0] dlc, input bit rtr, input bit fd);
    int b;
    if (rtr && !fd) return 0;
    if (dlc <= 8) b = int'(dlc);
    else if (!fd) b = 8;
    else begin
      case (dlc)
        9: b = 12; 10: b = 16; 11: b = 20; 12: b = 24; 13: b = 32; 14: b = 48;
        default: b = 64;
      endcase
    end
    return (b + 3) / 4;
  endfunction

  // ---------------- reference model ----------------
  logic [31:0] mq_w[$];
  string       mq_t[$];
  logic [31:0] pq_w[$];
  string       pq_t[$];
  bit          m_in, m_hdr, m_drop, m_ovr;
  int          m_need, m_rdpos, m_wrpos;
  logic [63:0] m_ts;

  always @(posedge clk) begin
    if (rst) begin
      mq_w.delete(); mq_t.delete(); pq_w.delete(); pq_t.delete();
      m_in = 0; m_hdr = 0; m_drop = 0; m_ovr = 0; m_need = 0;
      m_rdpos = 0; m_wrpos = 0; m_ts = 0;
    end else begin
      automatic bit can_rd = mq_w.size() > 0;
      automatic int free = DEPTH - mq_w.size();
      automatic bit set_ovr = 0;
      if (sof_i || abort_i) begin
        pq_w.delete(); pq_t.delete();
        m_in = sof_i; m_hdr = 0; m_drop = 0; m_need = 0;
        if (sof_i) m_ts = ts_i;
      end else if (commit_i) begin
        if (m_in && !m_drop) begin
          foreach (pq_w[i]) begin mq_w.push_back(pq_w[i]); mq_t.push_back(pq_t[i]); end
          m_wrpos = (m_wrpos + pq_w.size()) % DEPTH;
        end
        pq_w.delete(); pq_t.delete();
        m_in = 0; m_hdr = 0; m_drop = 0; m_need = 0;
      end else if (hdr_i && m_in && !m_hdr && !m_drop) begin
        automatic int nd = exp_ndata(dlc_i, rtr_i, fd_i);
        if (4 + nd > free) begin
          m_drop = 1; set_ovr = 1;
        end else begin
          automatic logic [31:0] f = {19'd0, 5'(nd + 3), esi_i, fd_i, ext_id_i, rtr_i, dlc_i};
          m_hdr = 1; m_need = nd;
          pq_w.push_back(f);                  pq_t.push_back("R3 format word");
          pq_w.push_back({3'b000, id_i});     pq_t.push_back("R2 identifier word");
          pq_w.push_back(m_ts[31:0]);         pq_t.push_back("R2 timestamp low");
          pq_w.push_back(m_ts[63:32]);        pq_t.push_back("R2 timestamp high");
        end
      end else if (data_we_i && m_in && m_hdr && !m_drop && m_need > 0) begin
        pq_w.push_back(data_i); pq_t.push_back("R4 data word");
        m_need--;
      end
      if (set_ovr) m_ovr = 1;
      else if (ovr_clr_i) m_ovr = 0;
      if (rd_adv_i && can_rd) begin
        void'(mq_w.pop_front()); void'(mq_t.pop_front());
        m_rdpos = (m_rdpos + 1) % DEPTH;
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(empty_o == (mq_w.size() == 0), "R5 empty flag", 64'(empty_o), 64'(mq_w.size() == 0));
      chk(ovr_o == m_ovr, "R7 overrun flag", 64'(ovr_o), 64'(m_ovr));
      chk(rd_pos_o == 12'(m_rdpos), "R8 read position", 64'(rd_pos_o), 64'(m_rdpos));
      chk(wr_pos_o == 12'(m_wrpos), "R9 write position", 64'(wr_pos_o), 64'(m_wrpos));
      if (mq_w.size() > 0)
        chk(rd_word_o == mq_w[0], mq_t[0], 64'(rd_word_o), 64'(mq_w[0]));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk_word(input logic [28:0] id, input int i);
    logic [7:0] b0 = 8'(id[7:0] + 8'(i * 4));
    return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
  endfunction

  // abort_at: -1 commit, -2 leave open, otherwise abort before that strobe.
  task automatic send_frame(input logic [3:0] dlc, input bit rtr, input bit fd,
                            input bit ext, input bit esi, input logic [28:0] id,
                            input int nstrobe, input int abort_at);
    @(negedge clk) sof_i = 1;
    @(negedge clk) sof_i = 0;
    @(negedge clk);
    dlc_i = dlc; rtr_i = rtr; fd_i = fd; ext_id_i = ext; esi_i = esi; id_i = id;
    hdr_i = 1;
    @(negedge clk) hdr_i = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < nstrobe; i++) begin
      if (i == abort_at) begin
        abort_i = 1;
        @(negedge clk) abort_i = 0;
        return;
      end
      data_i = mk_word(id, i); data_we_i = 1;
      @(negedge clk) data_we_i = 0;
      @(negedge clk);
    end
    if (abort_at == -2) return;
    commit_i = 1;
    @(negedge clk) commit_i = 0;
  endtask

  task automatic read_all();
    while (!empty_o) begin
      rd_adv_i = 1;
      @(negedge clk) rd_adv_i = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(empty_o == 1'b1, "R1 empty after reset", 64'(empty_o), 64'd1);
    chk(ovr_o == 1'b0, "R1 overrun after reset", 64'(ovr_o), 64'd0);
    chk(rd_pos_o == 0 && wr_pos_o == 0, "R1 positions after reset",
        {rd_pos_o, wr_pos_o}, 64'd0);

    send_frame(4'd8, 0, 0, 1, 0, 29'h1BCD_EF01, 2, -1); read_all();   // classic 8 bytes
    send_frame(4'd15, 0, 1, 0, 1, 29'h0000_07A3, 16, -1); read_all(); // FD 64 bytes
    send_frame(4'd4, 1, 0, 0, 0, 29'h0000_0123, 0, -1); read_all();   // classic remote
    send_frame(4'd9, 1, 1, 1, 0, 29'h0ABC_0001, 3, -1); read_all();   // FD with remote flag
    send_frame(4'd12, 0, 0, 0, 0, 29'h0000_0456, 2, -1); read_all();  // classic code 12 -> 8 bytes
    send_frame(4'd2, 0, 0, 0, 0, 29'h0000_0011, 3, -1); read_all();   // R4 surplus strobe

    // R6 abort mid-data
    begin
      automatic logic [11:0] wp = wr_pos_o;
      send_frame(4'd10, 0, 1, 0, 0, 29'h0000_0777, 4, 2);
      repeat (3) @(negedge clk);
      chk(wr_pos_o == wp, "R6 write position after abort", 64'(wr_pos_o), 64'(wp));
      chk(empty_o == 1'b1, "R6 nothing visible after abort", 64'(empty_o), 64'd1);
      send_frame(4'd6, 0, 0, 0, 0, 29'h0000_0888, 2, -2);  // left open
      send_frame(4'd3, 0, 0, 1, 1, 29'h1000_0002, 1, -1);  // restart replaces it
      read_all();
    end

    // R8 read while empty
    begin
      automatic logic [11:0] rp = rd_pos_o;
      repeat (3) begin rd_adv_i = 1; @(negedge clk) rd_adv_i = 0; end
      chk(rd_pos_o == rp, "R8 read while empty ignored", 64'(rd_pos_o), 64'(rp));
    end

    // R7 fill to exactly full, with one refusal
    for (int k = 0; k < 3; k++) send_frame(4'd15, 0, 1, 0, 0, 29'(k + 40), 16, -1);
    send_frame(4'd15, 0, 1, 0, 0, 29'd99, 16, -1);
    chk(ovr_o == 1'b1, "R7 overrun on refused frame", 64'(ovr_o), 64'd1);
    send_frame(4'd0, 0, 0, 0, 0, 29'd55, 0, -1);
    chk(ovr_o == 1'b1, "R7 overrun stays set", 64'(ovr_o), 64'd1);
    ovr_clr_i = 1;
    @(negedge clk) ovr_clr_i = 0;
    chk(ovr_o == 1'b0, "R7 overrun cleared", 64'(ovr_o), 64'd0);
    read_all();
    send_frame(4'd5, 0, 0, 0, 0, 29'd77, 2, -1);
    chk(empty_o == 1'b0, "R7 storing resumes after clear", 64'(empty_o), 64'd0);
    read_all();

    // wraparound traffic
    for (int k = 0; k < 8; k++) begin
      send_frame(4'(k * 2 + 1), 0, k[0], k[1], k[2], 29'(k * 1001), 16, -1);
      read_all();
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule